// File: doc/BRIEF.md
# Dual-Operand Memory-Mapped Result Processor

This block is a small single-issue processor core that completes one instruction on every clock. Instructions come from a read-only program memory addressed by the program counter, and operands and results live in a data RAM. The datapath holds only two operand registers, A and B, plus a staging register C that carries an immediate value toward memory.

There is no register file and no general arithmetic opcode. The sum of A and B, the logical right shift of A by B, and the unsigned test A > B are always computed in parallel from the operand registers. Each derived result has its own store opcode that writes it to a RAM address. Adding two RAM words therefore takes three instructions: load A, load B, store sum. Control flow is an unconditional jump or a jump taken when A is greater than B.

The program memory and data RAM are read combinationally, so a load's value is usable by the very next instruction. RAM writes take effect at the clock edge that ends the store instruction.

Top module: `dmr_core`

## Requirements
- R1: An instruction word is 24 bits, with the opcode in bits 23:18 and an 18-bit field in bits 17:0. The program memory address equals the program counter, and the data RAM address equals the field of the current instruction.
- R2: Opcode 1 copies the RAM word at the field address into A, and opcode 2 copies it into B. The new value is used by the next instruction.
- R3: Opcode 3 loads C with the low data-width bits of the field.
- R4: Opcode 4 asserts ram_we with ram_wdata equal to C, at the field address.
- R5: Opcode 5 asserts ram_we with ram_wdata equal to (A + B) modulo 2^width.
- R6: Opcode 6 asserts ram_wdata equal to A shifted right logically by B places, which is zero when B is at least the data width.
- R7: Opcode 7 loads the program counter with the field when A > B (unsigned). Otherwise the program counter goes to PC + 1.
- R8: Opcode 8 always loads the program counter with the field.
- R9: Opcode 0 and every opcode from 9 to 63 write no RAM, leave A, B and C unchanged, and advance the program counter by one.
- R10: Synchronous active-high reset clears A, B, C and the program counter to zero. ram_we stays low in every reset cycle.
- R11: Outside jumps the program counter advances by one modulo 2^18, so address 0x3FFFF is followed by 0. ram_we is high only for opcodes 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_addr | output | 18 | Program memory read address (program counter) |
| rom_data | input | 24 | Instruction word at rom_addr, same cycle |
| ram_addr | output | 18 | Data RAM address (instruction field) |
| ram_rdata | input | DW | Data RAM word at ram_addr, same cycle |
| ram_we | output | 1 | Data RAM write enable for this cycle |
| ram_wdata | output | DW | Data RAM write value |

## Verification
The bench targets these corner cases:
- An immediate wider than the data width, which must truncate rather than saturate.
- A sum that overflows and must wrap.
- A shift count equal to or larger than the width, which must give zero rather than a rotated or partly shifted value.
- The conditional jump with A equal to B and with A below B, both of which must fall through.

A design with a signed or greater-or-equal compare would branch on the equal case, and one that used the stale operand would branch wrongly right after a load. The bench also runs undefined opcodes, including 63, that must change nothing. It makes a jump to 0x3FFFF so that the program counter must wrap to 0, and it applies a reset in the middle of a run while a store is being fetched; a design that let that write through, or kept stale registers, would show a wrong value in the first stores after reset.

// File: rtl/dmr_pkg.sv
package dmr_pkg;
    localparam int OPW  = 6;
    localparam int FLDW = 18;
    localparam int IW   = OPW + FLDW;

    typedef enum logic [OPW-1:0] {
        OP_NOP   = 6'd0,
        OP_LDA   = 6'd1,
        OP_LDB   = 6'd2,
        OP_SETC  = 6'd3,
        OP_STC   = 6'd4,
        OP_STSUM = 6'd5,
        OP_STSHR = 6'd6,
        OP_JGT   = 6'd7,
        OP_JMP   = 6'd8
    } opcode_e;

    typedef enum logic [1:0] {
        SRC_C   = 2'd0,
        SRC_SUM = 2'd1,
        SRC_SHR = 2'd2
    } wsrc_e;

    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [FLDW-1:0] fld;
    } instr_t;

    typedef struct packed {
        logic  ld_a;
        logic  ld_b;
        logic  set_c;
        logic  store;
        wsrc_e src;
        logic  jmp;
        logic  jgt;
    } ctrl_t;

    function automatic instr_t split_word(input logic [IW-1:0] w);
        return instr_t'(w);
    endfunction

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c = '0;
        c.src = SRC_C;
        return c;
    endfunction
endpackage

// File: rtl/dmr_decode.sv
module dmr_decode
    import dmr_pkg::*;
(
    input  instr_t ins,
    output ctrl_t  ctrl
);
    always_comb begin
        ctrl = ctrl_idle();
        case (ins.op)
            OP_LDA:   ctrl.ld_a  = 1'b1;
            OP_LDB:   ctrl.ld_b  = 1'b1;
            OP_SETC:  ctrl.set_c = 1'b1;
            OP_STC: begin
                ctrl.store = 1'b1;
                ctrl.src   = SRC_C;
            end
            OP_STSUM: begin
                ctrl.store = 1'b1;
                ctrl.src   = SRC_SUM;
            end
            OP_STSHR: begin
                ctrl.store = 1'b1;
                ctrl.src   = SRC_SHR;
            end
            OP_JGT:   ctrl.jgt = 1'b1;
            OP_JMP:   ctrl.jmp = 1'b1;
            default:  ctrl = ctrl_idle();
        endcase
    end
endmodule

// File: rtl/dmr_results.sv
module dmr_results
    import dmr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] c,
    input  wsrc_e         src,
    output logic          gt,
    output logic [DW-1:0] wdata
);
    logic [DW-1:0] sum_r;
    logic [DW-1:0] shr_r;

    // Every derived result is live at all times; the store opcode only picks one.
    assign sum_r = a + b;
    assign shr_r = a >> b;
    assign gt    = (a > b);

    always_comb begin
        case (src)
            SRC_SUM: wdata = sum_r;
            SRC_SHR: wdata = shr_r;
            default: wdata = c;
        endcase
    end
endmodule

// File: rtl/dmr_pc_next.sv
module dmr_pc_next
    import dmr_pkg::*;
(
    input  logic [FLDW-1:0] pc,
    input  logic [FLDW-1:0] target,
    input  logic            jmp,
    input  logic            jgt,
    input  logic            gt,
    output logic [FLDW-1:0] pc_nxt
);
    logic take;

    assign take   = jmp | (jgt & gt);
    assign pc_nxt = take ? target : pc + FLDW'(1);
endmodule

// File: rtl/dmr_core.sv
module dmr_core
    import dmr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst,
    output logic [FLDW-1:0] rom_addr,
    input  logic [IW-1:0]   rom_data,
    output logic [FLDW-1:0] ram_addr,
    input  logic [DW-1:0]   ram_rdata,
    output logic            ram_we,
    output logic [DW-1:0]   ram_wdata
);
    instr_t          ins;
    ctrl_t           ctrl;
    logic [FLDW-1:0] pc_q;
    logic [FLDW-1:0] pc_nxt;
    logic [DW-1:0]   a_q;
    logic [DW-1:0]   b_q;
    logic [DW-1:0]   c_q;
    logic            gt;
    logic [DW-1:0]   wdata;

    assign ins = split_word(rom_data);

    dmr_decode u_dec (
        .ins  (ins),
        .ctrl (ctrl)
    );

    dmr_results #(.DW(DW)) u_res (
        .a     (a_q),
        .b     (b_q),
        .c     (c_q),
        .src   (ctrl.src),
        .gt    (gt),
        .wdata (wdata)
    );

    dmr_pc_next u_pcn (
        .pc     (pc_q),
        .target (ins.fld),
        .jmp    (ctrl.jmp),
        .jgt    (ctrl.jgt),
        .gt     (gt),
        .pc_nxt (pc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            a_q  <= '0;
            b_q  <= '0;
            c_q  <= '0;
        end else begin
            pc_q <= pc_nxt;
            if (ctrl.ld_a)  a_q <= ram_rdata;
            if (ctrl.ld_b)  b_q <= ram_rdata;
            if (ctrl.set_c) c_q <= ins.fld[DW-1:0];
        end
    end

    assign rom_addr  = pc_q;
    assign ram_addr  = ins.fld;
    assign ram_we    = ctrl.store & ~rst;
    assign ram_wdata = wdata;

    // ---------------- assertions ----------------
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R10: no write leaves the core while reset is held
    always_comb begin
        if (rst === 1'b1) begin
            p_reset_quiet_r10: assert (ram_we == 1'b0);
        end
    end

    // R10: state is zero on the first cycle after reset
    always_ff @(posedge clk) begin
        if (rst == 1'b0 && rst_q === 1'b1) begin
            p_reset_clear_r10: assert (pc_q == '0 && a_q == '0 && b_q == '0 && c_q == '0);
        end
    end

    p_load_a_r2: assert property (@(posedge clk) disable iff (rst)
        (rom_data[IW-1:FLDW] == 6'd1) |=> (a_q == $past(ram_rdata)));

    p_load_b_r2: assert property (@(posedge clk) disable iff (rst)
        (rom_data[IW-1:FLDW] == 6'd2) |=> (b_q == $past(ram_rdata)));

    p_set_c_r3: assert property (@(posedge clk) disable iff (rst)
        (rom_data[IW-1:FLDW] == 6'd3) |=> (c_q == $past(rom_data[DW-1:0])));

    p_jump_r8: assert property (@(posedge clk) disable iff (rst)
        (rom_data[IW-1:FLDW] == 6'd8) |=> (rom_addr == $past(rom_data[FLDW-1:0])));

    p_jgt_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (rom_data[IW-1:FLDW] == 6'd7 && !(a_q > b_q)) |=> (rom_addr == $past(rom_addr) + FLDW'(1)));

    p_we_store_only_r11: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (rom_data[IW-1:FLDW] >= 6'd4 && rom_data[IW-1:FLDW] <= 6'd6));

    p_undef_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (rom_data[IW-1:FLDW] == 6'd0 || rom_data[IW-1:FLDW] > 6'd8)
        |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)
             && rom_addr == $past(rom_addr) + FLDW'(1)));
endmodule

// File: tb/dmr_core_tb.sv
`timescale 1ns/1ps
module dmr_core_tb_top;
    localparam int DW  = 16;
    localparam int FW  = 18;
    localparam int RUN = 260;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [FW-1:0] rom_addr;
    logic [23:0]   rom_data;
    logic [FW-1:0] ram_addr;
    logic [DW-1:0] ram_rdata;
    logic          ram_we;
    logic [DW-1:0] ram_wdata;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    dmr_core #(.DW(DW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .ram_addr  (ram_addr),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata)
    );

    function automatic logic [23:0] mk(input int op, input int fld);
        return {6'(op), 18'(fld)};
    endfunction

    // Test program: opcodes per the brief (1 lda, 2 ldb, 3 setc, 4 stc, 5 sum, 6 shr, 7 jgt, 8 jmp)
    function automatic logic [23:0] prog(input logic [FW-1:0] adr);
        case (adr)
            18'd0:  return mk(4, 100);       // store C (zero after reset)
            18'd1:  return mk(5, 101);       // store A+B (zero after reset)
            18'd2:  return mk(3, 18'h3FFFF); // set C with wide immediate
            18'd3:  return mk(4, 10);
            18'd4:  return mk(3, 3);
            18'd5:  return mk(4, 11);
            18'd6:  return mk(1, 10);
            18'd7:  return mk(2, 11);
            18'd8:  return mk(5, 12);        // wrapping sum
            18'd9:  return mk(6, 13);        // shift by 3
            18'd10: return mk(3, 20);
            18'd11: return mk(4, 14);
            18'd12: return mk(2, 14);
            18'd13: return mk(6, 15);        // shift by width+4
            18'd14: return mk(7, 20);        // taken
            18'd15: return mk(63, 5);
            18'd20: return mk(1, 14);        // A == B
            18'd21: return mk(7, 40);        // not taken
            18'd22: return mk(9, 12);        // undefined
            18'd23: return mk(4, 16);
            18'd24: return mk(1, 11);
            18'd25: return mk(7, 40);        // A < B: not taken
            18'd26: return mk(2, 12);
            18'd27: return mk(7, 30);        // load then compare, taken
            18'd28: return mk(63, 7);
            18'd30: return mk(5, 17);
            18'd31: return mk(63, 0);
            18'd32: return mk(8, 18'h3FFFF); // jump to top, then wrap
            default: return mk(0, 0);
        endcase
    endfunction

    logic [DW-1:0] mem [256] = '{default: '0};
    always_comb rom_data  = prog(rom_addr);
    always_comb ram_rdata = mem[ram_addr[7:0]];
    always @(posedge clk) if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;

    // Behavioural reference state
    logic [FW-1:0] m_pc;
    logic [DW-1:0] m_a, m_b, m_c;
    logic [DW-1:0] m_mem [256];
    string         pc_tag;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        int op;
        logic [FW-1:0] fld;
        logic [23:0]   w;
        logic          exp_we;
        logic [DW-1:0] exp_wd;
        string         st_tag;
        foreach (m_mem[i]) m_mem[i] = '0;
        m_pc = '0; m_a = '0; m_b = '0; m_c = '0; pc_tag = "R10";
        for (int cyc = 0; cyc < RUN; cyc++) begin
            @(negedge clk);
            rst = (cyc < 3) || (cyc == 140) || (cyc == 141);
            #1;
            w   = prog(m_pc);
            op  = int'(w[23:18]);
            fld = w[17:0];
            if (cyc >= 3) begin
                check(rom_addr == m_pc, pc_tag, 32'(rom_addr), 32'(m_pc));
                exp_we = !rst && (op >= 4 && op <= 6);
                st_tag = rst ? "R10" : ((op >= 4 && op <= 6) ? "R11" : "R9");
                check(ram_we == exp_we, st_tag, 32'(ram_we), 32'(exp_we));
                if (!rst && op >= 1 && op <= 6)
                    check(ram_addr == fld, "R1", 32'(ram_addr), 32'(fld));
                if (exp_we) begin
                    case (op)
                        4: begin exp_wd = m_c; st_tag = "R4"; end
                        5: begin exp_wd = m_a + m_b; st_tag = "R5"; end
                        default: begin
                            exp_wd = (m_b >= DW) ? '0 : (m_a >> m_b);
                            st_tag = "R6";
                        end
                    endcase
                    check(ram_wdata == exp_wd, st_tag, 32'(ram_wdata), 32'(exp_wd));
                end
            end
            // advance the model by one instruction
            if (rst) begin
                m_pc = '0; m_a = '0; m_b = '0; m_c = '0; pc_tag = "R10";
            end else begin
                pc_tag = "R11";
                case (op)
                    1: begin m_a = m_mem[fld[7:0]]; pc_tag = "R2"; end
                    2: begin m_b = m_mem[fld[7:0]]; pc_tag = "R2"; end
                    3: begin m_c = fld[DW-1:0]; pc_tag = "R3"; end
                    4: m_mem[fld[7:0]] = m_c;
                    5: m_mem[fld[7:0]] = m_a + m_b;
                    6: m_mem[fld[7:0]] = (m_b >= DW) ? '0 : (m_a >> m_b);
                    7: pc_tag = "R7";
                    8: pc_tag = "R8";
                    default: pc_tag = "R9";
                endcase
                if (op == 8 || (op == 7 && m_a > m_b)) m_pc = fld;
                else m_pc = m_pc + 1'b1;
            end
        end
        // spot checks of memory against values derived by hand
        check(mem[10] == 16'hFFFF, "R3", 32'(mem[10]), 32'hFFFF);
        check(mem[12] == 16'h0002, "R5", 32'(mem[12]), 32'h0002);
        check(mem[15] == 16'h0000, "R6", 32'(mem[15]), 32'h0000);
        check(mem[17] == 16'h0005, "R7", 32'(mem[17]), 32'h0005);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule